// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block sits beside a processor core and measures how the core behaves. It has four event counters and one cycle counter, each 32 bits wide. Each event counter watches one line of a 256-line event bus. It counts either the number of times that line rises or the number of cycles during which that line stays high. The cycle counter counts core clocks, which gives a time base against which event counts can be compared.

Software reaches the block through a single-cycle register port. Each access is addressed by two 4-bit register-number fields, here called `acc_crn` and `acc_crm`. A read returns data combinationally in the same cycle. A write takes effect at the next rising clock edge. Every access must have the privileged flag set. Without it, the access is refused: a read returns zero and a write changes nothing.

When a counter wraps from all-ones to zero, it sets a sticky overflow flag and keeps counting. A registered interrupt line goes high when any flag is set and its enable bit is also set.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters are zero, the enable bit is clear, the event codes are zero, the interrupt enables are zero and the overflow flags are zero, so every register reads as zero. `irq` is low.
- R2: Registers are addressed by the pair (crn, crm):
  - (0,1) control
  - (1,1) cycle counter
  - (4,1) interrupt enables
  - (5,1) overflow flags
  - (8,1) event codes
  - (0,2), (1,2), (2,2), (3,2) event counters 0 to 3

  Any other pair reads as zero, and a write to any other pair changes no register.
- R3: An access with `acc_priv` low is refused. A refused read returns zero. A refused write changes no register.
- R4: The control register has three bits that take effect on write:
  - bit 0 is the enable for all counting;
  - writing 1 to bit 1 clears all four event counters at that edge;
  - writing 1 to bit 2 clears the cycle counter at that edge.

  A read of the control register returns only bit 0. All other bits read as zero.
- R5: While the enable is set, the cycle counter advances by one on every clock. While the enable is clear, it holds its value. A written value is loaded at the write edge.
- R6: Byte i of the event-code register holds the 8-bit code for event counter i. The code is the index of the event line that the counter watches.
- R7: A code with bit 7 clear selects occurrence counting: the counter advances by one for each low-to-high transition of the selected event line.
- R8: A code with bit 7 set selects duration counting: the counter advances by one for every clock edge at which the selected event line is high.
- R9: When a counter wraps from all-ones to zero, it keeps counting and sets its overflow flag. Flag bit 0 belongs to the cycle counter, and flag bits 1 to 4 belong to event counters 0 to 3.
- R10: An overflow flag stays set until software writes 1 to that bit of the flag register. Writing 0 to a flag bit leaves it unchanged.
- R11: `irq` is a register. It goes high one clock after any flag bit is set together with the matching interrupt-enable bit (bits laid out as in R9). It goes low one clock after no enabled flag remains.
- R12: When software writes an event counter in the same cycle that the counter would advance, the written value is loaded and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A register access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | The access comes from privileged mode |
| acc_crn | input | 4 | First register-number field |
| acc_crm | input | 4 | Second register-number field |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the same cycle as the read |
| events | input | 256 | Event lines from the core |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so the bench drives each access just after a falling edge and samples `acc_rdata` 1 ns later, before the next rising edge. Writes, counter increments and wraps become visible at the rising edge that follows, so each write task returns at the next falling edge and the following read sees the new state. The interrupt line has one more register stage. The bench therefore checks that `irq` is still low on the falling edge just after the wrap, high one cycle later, still high just after the clearing write, and low one cycle after that. Counts are exact: each event pattern is applied for a known number of falling-edge-to-falling-edge cycles, and the expected total is worked out from the number of rising edges or high cycles in that pattern.

// File: rtl/perf_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the performance monitor.
// Assumes the register port is 32 bits wide and both address fields are 4 bits.
package perf_mon_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Values of the second address field
    localparam logic [ADDR_W-1:0] CRM_SYS = 4'd1;
    localparam logic [ADDR_W-1:0] CRM_CNT = 4'd2;

    // Values of the first address field for the system registers
    localparam logic [ADDR_W-1:0] CRN_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] CRN_CCNT  = 4'd1;
    localparam logic [ADDR_W-1:0] CRN_INTEN = 4'd4;
    localparam logic [ADDR_W-1:0] CRN_FLAG  = 4'd5;
    localparam logic [ADDR_W-1:0] CRN_EVSEL = 4'd8;

    // Bit positions in the control register
    localparam int CTRL_EN      = 0;
    localparam int CTRL_CLR_EVT = 1;
    localparam int CTRL_CLR_CYC = 2;

    // One-hot selection of a system register
    typedef struct packed {
        logic ctrl;
        logic ccnt;
        logic inten;
        logic flag;
        logic evsel;
    } sys_sel_t;

endpackage

// File: rtl/pm_decode.sv
`timescale 1ns/1ps
// Module: pm_decode
// Decodes an access into write and read strobes and a one-hot register select.
// Assumes at most one access per cycle. Unprivileged accesses give no strobe.
module pm_decode
    import perf_mon_pkg::*;
#(
    parameter int N_EVT = 4
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [ADDR_W-1:0] acc_crn,
    input  logic [ADDR_W-1:0] acc_crm,
    output logic              wr_stb,
    output logic              rd_stb,
    output sys_sel_t          sys_sel,
    output logic [N_EVT-1:0]  cnt_sel
);

    // Only privileged accesses produce a strobe
    assign wr_stb = acc_valid && acc_priv && acc_write;
    assign rd_stb = acc_valid && acc_priv && !acc_write;

    // Match the system registers
    always_comb begin
        sys_sel       = '0;
        sys_sel.ctrl  = (acc_crm == CRM_SYS) && (acc_crn == CRN_CTRL);
        sys_sel.ccnt  = (acc_crm == CRM_SYS) && (acc_crn == CRN_CCNT);
        sys_sel.inten = (acc_crm == CRM_SYS) && (acc_crn == CRN_INTEN);
        sys_sel.flag  = (acc_crm == CRM_SYS) && (acc_crn == CRN_FLAG);
        sys_sel.evsel = (acc_crm == CRM_SYS) && (acc_crn == CRN_EVSEL);
    end

    // Match the event counters, one per value of the first field
    for (genvar i = 0; i < N_EVT; i++) begin : g_cnt_sel
        assign cnt_sel[i] = (acc_crm == CRM_CNT) && (acc_crn == ADDR_W'(i));
    end

endmodule

// File: rtl/pm_counter.sv
`timescale 1ns/1ps
// Module: pm_counter
// Wrapping up-counter with load and clear.
// Priority: load first, then clear, then increment.
// wrap pulses in the cycle in which an increment takes the count from all-ones to zero.
module pm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic [CNT_W-1:0] value,
    output logic             wrap
);

    // Count register; an increment is dropped when a load or clear happens in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (load)  value <= load_val;
        else if (clear) value <= '0;
        else if (inc)   value <= value + 1'b1;
    end

    // Wrap indication for the overflow flag
    assign wrap = inc && !load && !clear && (value == '1);

endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
// Module: perf_mon_unit
// Performance monitor with N_EVT event counters and one cycle counter.
// Register access is single-cycle: reads are combinational and writes take effect at the next edge.
// Assumes N_EVT * CODE_W <= 32, N_EVT + 1 <= 32 and CNT_W <= 32.
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int N_EVT    = 4,
    parameter int CNT_W    = 32,
    parameter int N_EVENTS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_priv,
    input  logic [ADDR_W-1:0]   acc_crn,
    input  logic [ADDR_W-1:0]   acc_crm,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic [DATA_W-1:0]   acc_rdata,
    input  logic [N_EVENTS-1:0] events,
    output logic                irq
);

    localparam int CODE_W = $clog2(N_EVENTS);
    localparam int SEL_W  = N_EVT * CODE_W;
    localparam int NFLAG  = N_EVT + 1;

    logic              wr_stb, rd_stb;
    sys_sel_t          sys_sel;
    logic [N_EVT-1:0]  cnt_sel;

    logic              ctrl_en_q;
    logic [NFLAG-1:0]  inten_q;
    logic [NFLAG-1:0]  flag_q;
    logic [SEL_W-1:0]  evsel_q;
    logic              irq_q;
    logic [NFLAG-1:0]  wrap_vec;
    logic [CNT_W-1:0]  ccnt_val;
    logic [CNT_W-1:0]  pmn_val [N_EVT];
    logic              clr_evt, clr_cyc;
    logic [NFLAG-1:0]  flag_clr;

    pm_decode #(.N_EVT(N_EVT)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_priv  (acc_priv),
        .acc_crn   (acc_crn),
        .acc_crm   (acc_crm),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .sys_sel   (sys_sel),
        .cnt_sel   (cnt_sel)
    );

    // Clear pulses decoded from a write to the control register
    assign clr_evt = wr_stb && sys_sel.ctrl && acc_wdata[CTRL_CLR_EVT];
    assign clr_cyc = wr_stb && sys_sel.ctrl && acc_wdata[CTRL_CLR_CYC];

    // Configuration registers: enable, interrupt enables, event codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            inten_q   <= '0;
            evsel_q   <= '0;
        end else if (wr_stb) begin
            if (sys_sel.ctrl)  ctrl_en_q <= acc_wdata[CTRL_EN];
            if (sys_sel.inten) inten_q   <= acc_wdata[NFLAG-1:0];
            if (sys_sel.evsel) evsel_q   <= acc_wdata[SEL_W-1:0];
        end
    end

    pm_counter #(.CNT_W(CNT_W)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ctrl_en_q),
        .load     (wr_stb && sys_sel.ccnt),
        .load_val (acc_wdata[CNT_W-1:0]),
        .clear    (clr_cyc),
        .value    (ccnt_val),
        .wrap     (wrap_vec[0])
    );

    // One event selector and one counter per event counter
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        logic [CODE_W-1:0] code;
        logic              cur, prev_q, inc;

        assign code = evsel_q[i*CODE_W +: CODE_W];
        assign cur  = events[code];
        assign inc  = ctrl_en_q && (code[CODE_W-1] ? cur : (cur && !prev_q));

        // Previous level of the selected line, used to detect a rising edge
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= cur;
        end

        pm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc),
            .load     (wr_stb && cnt_sel[i]),
            .load_val (acc_wdata[CNT_W-1:0]),
            .clear    (clr_evt),
            .value    (pmn_val[i]),
            .wrap     (wrap_vec[i+1])
        );
    end

    // Flag bits written with 1 are cleared
    assign flag_clr = (wr_stb && sys_sel.flag) ? acc_wdata[NFLAG-1:0] : '0;

    // Sticky overflow flags; a wrap in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | wrap_vec;
    end

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & inten_q);
    end
    assign irq = irq_q;

    // Read multiplexer; refused and unmapped reads return zero
    always_comb begin
        acc_rdata = '0;
        if (rd_stb) begin
            if (sys_sel.ctrl)  acc_rdata = DATA_W'(ctrl_en_q);
            if (sys_sel.ccnt)  acc_rdata = DATA_W'(ccnt_val);
            if (sys_sel.inten) acc_rdata = DATA_W'(inten_q);
            if (sys_sel.flag)  acc_rdata = DATA_W'(flag_q);
            if (sys_sel.evsel) acc_rdata = DATA_W'(evsel_q);
            for (int i = 0; i < N_EVT; i++) begin
                if (cnt_sel[i]) acc_rdata = DATA_W'(pmn_val[i]);
            end
        end
    end

endmodule

// File: rtl/pm_checker.sv
`timescale 1ns/1ps
// Module: pm_checker
// Concurrent properties for perf_mon_unit, attached with the bind below.
// Assumes CNT_W <= 32 and NFLAG <= 32.
module pm_checker #(
    parameter int CNT_W = 32,
    parameter int NFLAG = 5,
    parameter int SEL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_priv,
    input logic [3:0]       acc_crn,
    input logic [3:0]       acc_crm,
    input logic [31:0]      acc_wdata,
    input logic [31:0]      acc_rdata,
    input logic             irq,
    input logic             ctrl_en,
    input logic [NFLAG-1:0] inten,
    input logic [NFLAG-1:0] flag,
    input logic [SEL_W-1:0] evsel,
    input logic [CNT_W-1:0] ccnt,
    input logic [CNT_W-1:0] pmn0
);

    logic pw;
    logic ccnt_touched;
    assign pw           = acc_valid && acc_write && acc_priv;
    assign ccnt_touched = pw && (acc_crm == 4'd1) && (acc_crn == 4'd0 || acc_crn == 4'd1);

    a_r3_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && !acc_priv |-> acc_rdata == 32'd0);

    a_r3_refused_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && !acc_priv |=> $stable(inten) && $stable(evsel) && $stable(ctrl_en));

    a_r4_ctrl_reads_bit0_only: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && acc_priv && acc_crm == 4'd1 && acc_crn == 4'd0
        |-> acc_rdata[31:1] == 31'd0);

    a_r5_cycle_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en && !ccnt_touched |=> ccnt == $past(ccnt) + 1'b1);

    a_r9_cycle_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en && !ccnt_touched && ccnt == '1 |=> ccnt == '0 && flag[0]);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag[0] && !(pw && acc_crm == 4'd1 && acc_crn == 4'd5 && acc_wdata[0]) |=> flag[0]);

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        inten == '0 |=> !irq);

    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pw && acc_crm == 4'd2 && acc_crn == 4'd0 |=> pmn0 == $past(acc_wdata[CNT_W-1:0]));

endmodule

bind perf_mon_unit pm_checker #(.CNT_W(CNT_W), .NFLAG(NFLAG), .SEL_W(SEL_W)) u_pm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_priv  (acc_priv),
    .acc_crn   (acc_crn),
    .acc_crm   (acc_crm),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .irq       (irq),
    .ctrl_en   (ctrl_en_q),
    .inten     (inten_q),
    .flag      (flag_q),
    .evsel     (evsel_q),
    .ccnt      (ccnt_val),
    .pmn0      (pmn_val[0])
);

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each. Inputs change just after a falling edge;
// outputs are sampled at 1 ns after a falling edge.
module test_perf_mon_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [3:0]   acc_crn = '0, acc_crm = '0;
    logic [31:0]  acc_wdata = '0;
    logic [31:0]  acc_rdata;
    logic [255:0] events = '0;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_crn(acc_crn), .acc_crm(acc_crm),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .events(events), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write: present for one cycle; returns at the falling edge after the write edge
    task automatic wr(input logic [3:0] n, input logic [3:0] m, input logic [31:0] d,
                      input logic p = 1'b1);
        acc_valid = 1'b1; acc_write = 1'b1; acc_priv = p;
        acc_crn = n; acc_crm = m; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_priv = 1'b0;
    endtask

    // Read: sample 1 ns after presenting, then consume the cycle
    task automatic rd(input logic [3:0] n, input logic [3:0] m, output logic [31:0] q,
                      input logic p = 1'b1);
        acc_valid = 1'b1; acc_write = 1'b0; acc_priv = p;
        acc_crn = n; acc_crm = m;
        #1;
        q = acc_rdata;
        acc_valid = 1'b0; acc_priv = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] q;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(0, 1, q); check("R1 control", q, 0);
        rd(1, 1, q); check("R1 cycle counter", q, 0);
        rd(4, 1, q); check("R1 interrupt enables", q, 0);
        rd(5, 1, q); check("R1 flags", q, 0);
        rd(8, 1, q); check("R1 event codes", q, 0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i), 2, q); check("R1 event counter", q, 0);
        end
    endtask

    task automatic t_map();
        logic [31:0] q;
        wr(4, 1, 32'h1F);
        rd(4, 1, q); check("R2 enables at (4,1)", q, 32'h1F);
        rd(2, 1, q); check("R2 unmapped (2,1) reads zero", q, 0);
        rd(4, 2, q); check("R2 unmapped (4,2) reads zero", q, 0);
        wr(2, 1, 32'hFFFF_FFFF);
        rd(0, 1, q); check("R2 unmapped write leaves control", q, 0);
        rd(4, 1, q); check("R2 unmapped write leaves enables", q, 32'h1F);
        wr(4, 1, 32'h0);
    endtask

    task automatic t_priv();
        logic [31:0] q;
        wr(4, 1, 32'h1F, 1'b0);
        rd(4, 1, q); check("R3 refused write ignored", q, 0);
        wr(4, 1, 32'h3);
        rd(4, 1, q, 1'b0); check("R3 refused read is zero", q, 0);
        rd(4, 1, q); check("R3 privileged read", q, 32'h3);
        wr(4, 1, 32'h0);
    endtask

    task automatic t_clock();
        logic [31:0] q;
        wr(1, 1, 32'd100);
        rd(1, 1, q); check("R5 load value", q, 32'd100);
        repeat (3) @(negedge clk);
        rd(1, 1, q); check("R5 holds while disabled", q, 32'd100);
        wr(0, 1, 32'h1);
        rd(1, 1, q); check("R5 first sample after enable", q, 32'd100);
        repeat (4) @(negedge clk);
        rd(1, 1, q); check("R5 advances one per clock", q, 32'd105);
        wr(0, 1, 32'h5);
        rd(1, 1, q); check("R4 bit 2 clears cycle counter", q, 0);
        wr(0, 1, 32'h0);
        rd(1, 1, q); check("R5 count at disable", q, 32'd2);
        repeat (3) @(negedge clk);
        rd(1, 1, q); check("R5 frozen after disable", q, 32'd2);
    endtask

    task automatic t_events();
        logic [31:0] q;
        wr(8, 1, 32'h9010_8505);
        rd(8, 1, q); check("R6 event codes read back", q, 32'h9010_8505);
        wr(0, 1, 32'h3);
        rd(0, 1, q); check("R4 control reads only enable", q, 32'h1);
        events[5] = 1'b1; repeat (3) @(negedge clk);
        events[5] = 1'b0; repeat (2) @(negedge clk);
        events[5] = 1'b1; @(negedge clk);
        events[5] = 1'b0; repeat (2) @(negedge clk);
        events[133] = 1'b1; repeat (4) @(negedge clk);
        events[133] = 1'b0; @(negedge clk);
        rd(0, 2, q); check("R7 occurrence counts rising edges", q, 32'd2);
        rd(1, 2, q); check("R8 duration counts high cycles", q, 32'd4);
        rd(2, 2, q); check("R6 counter 2 watches line 16", q, 0);
        rd(3, 2, q); check("R6 counter 3 watches line 144", q, 0);
        wr(0, 1, 32'h3);
        rd(0, 2, q); check("R4 bit 1 clears counter 0", q, 0);
        rd(1, 2, q); check("R4 bit 1 clears counter 1", q, 0);
    endtask

    task automatic t_priority();
        logic [31:0] q;
        events[133] = 1'b1;
        @(negedge clk);
        wr(1, 2, 32'd1000);
        rd(1, 2, q); check("R12 write beats increment", q, 32'd1000);
        events[133] = 1'b0;
        rd(1, 2, q); check("R12 counting resumes after write", q, 32'd1001);
    endtask

    task automatic t_overflow();
        logic [31:0] q;
        wr(4, 1, 32'h04);
        wr(1, 2, 32'hFFFF_FFFE);
        events[133] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11 irq not yet up in wrap cycle", {31'd0, irq}, 0);
        @(negedge clk);
        check("R11 irq one clock after flag", {31'd0, irq}, 1);
        events[133] = 1'b0;
        rd(1, 2, q); check("R9 counting continues past wrap", q, 32'd1);
        rd(5, 1, q); check("R9 counter 1 sets flag bit 2", q, 32'h04);
        wr(5, 1, 32'h04);
        check("R11 irq held in clear cycle", {31'd0, irq}, 1);
        @(negedge clk);
        check("R11 irq drops after clear", {31'd0, irq}, 0);
        rd(5, 1, q); check("R10 write 1 clears flag", q, 0);
        wr(1, 1, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(5, 1, q); check("R9 cycle counter sets flag bit 0", q, 32'h01);
        check("R11 masked flag keeps irq low", {31'd0, irq}, 0);
        wr(5, 1, 32'h0);
        rd(5, 1, q); check("R10 write 0 keeps flag", q, 32'h01);
        wr(5, 1, 32'h1, 1'b0);
        rd(5, 1, q); check("R3 refused clear keeps flag", q, 32'h01);
        wr(5, 1, 32'h1);
        rd(5, 1, q); check("R10 clear of bit 0", q, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_priv();
        t_clock();
        t_events();
        t_priority();
        t_overflow();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule